// File: doc/BRIEF.md
# Line Range and Brown-Out Supervisor

This block watches a filtered image of the rectified AC input, delivered to it as a set of hysteretic comparator bits, and makes two decisions from it. The first is whether the converter runs from a low-line or a high-line supply. The resulting flag picks the on-time gain code for the modulator and, when follower boost is enabled, switches on the feedback offset that lowers the regulated output at low line. The second decision is whether the line has collapsed into brown-out.

The timing is deliberately lopsided. A rise above the high-line threshold returns the block to high line on the next clock. Low line is only taken after the image has stayed below its threshold for a persistence window that is longer than half a line period. While follower boost is enabled, a watchdog forces high line when switching has stayed idle for its own window. A brown-out fault, once it has persisted, does not stop the drive. It raises a ramp-down request that lets the control level decay, and the block only enters its off state when the static-overvoltage trip reports that the control level has reached its lower clamp. All windows are parameters counted in clock cycles.

Top module: `lrbo_supervisor`

## Requirements
- R1: Reset state: low_line=0, bo_fault=1, off_state=1, ramp_req=0.
- R2: With above_hl=1 at a clock edge, low_line is 0 after that edge, whatever the other inputs are.
- R3: low_line becomes 1 after LL_CYC consecutive edges with below_ll=1 and above_hl=0, and not before; one edge without that condition restarts the count.
- R4: With boost_en=1, LL_CYC consecutive idle edges are not enough on their own: WDG_CYC consecutive edges with sw_active=0 force low_line to 0, and it stays 0 while the idle condition lasts. With boost_en=0, idle switching has no effect on low_line.
- R5: While bo_fault=1, an edge with above_bo_exit=1 clears bo_fault, off_state and ramp_req (normal run).
- R6: In normal run, bo_fault becomes 1 after BO_CYC consecutive edges with below_bo_enter=1, and not before; one edge without it restarts the count.
- R7: A brown-out fault entered from normal run sets ramp_req=1 and keeps off_state=0, so switching continues.
- R8: With ramp_req=1, an edge with static_ovp_trip=1 (and above_bo_exit=0) sets off_state=1 and clears ramp_req. In normal run static_ovp_trip has no effect.
- R9: off_state holds, with ramp_req=0, until an edge with above_bo_exit=1 or a reset; recovery also works from the ramp-down.
- R10: ton_gain is GAIN_LL (default 5) in low line and GAIN_HL (default 2) in high line, a ratio of 2.5; fb_offset_en equals low_line AND boost_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| above_hl | input | 1 | Line image above the high-line threshold |
| below_ll | input | 1 | Line image below the low-line threshold |
| above_bo_exit | input | 1 | Line image above the brown-out exit threshold |
| below_bo_enter | input | 1 | Line image below the brown-out enter threshold |
| boost_en | input | 1 | Follower boost enabled |
| sw_active | input | 1 | Power switch is currently switching |
| static_ovp_trip | input | 1 | Control level has reached its lower clamp |
| low_line | output | 1 | 1 = low line, 0 = high line |
| ton_gain | output | 8 | On-time gain code for the modulator |
| fb_offset_en | output | 1 | Enable for the low-line feedback offset source |
| bo_fault | output | 1 | Brown-out fault |
| ramp_req | output | 1 | Request to ramp the control level down |
| off_state | output | 1 | Block in off state, drive stopped |

## Verification
Every result is a single register stage away from its inputs, so an immediate event such as a high-line crossing, a recovery or a trip is due one edge after the stimulus, and a persistence result is due on exactly the N-th consecutive qualifying edge. The bench drives inputs on falling edges and samples outputs on falling edges, checks each window one cycle short of expiry (still unchanged) and then one cycle later (changed), and restarts a window with a one-cycle break to prove the count was reset. The gain code and the offset enable are combinational from the flags and are checked in the same sample as the flag.

// File: rtl/lrbo_pkg.sv
package lrbo_pkg;
  localparam int GAIN_W = 8;

  typedef enum logic [1:0] {
    BO_OFF  = 2'd0,
    BO_RUN  = 2'd1,
    BO_RAMP = 2'd2
  } bo_state_e;

  function automatic logic [GAIN_W-1:0] pick_gain(
    input logic              low,
    input logic [GAIN_W-1:0] g_low,
    input logic [GAIN_W-1:0] g_high
  );
    return low ? g_low : g_high;
  endfunction
endpackage

// File: rtl/lrbo_persist.sv
module lrbo_persist #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LIM = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cond) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = cond && (cnt_q == LIM);
endmodule

// File: rtl/lrbo_line_sel.sv
module lrbo_line_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic go_high,
  input  logic wdg_hit,
  input  logic ll_hit,
  output logic low_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) low_line <= 1'b0;
    else if (go_high || wdg_hit) low_line <= 1'b0;
    else if (ll_hit) low_line <= 1'b1;
  end
endmodule

// File: rtl/lrbo_bo_ctrl.sv
module lrbo_bo_ctrl
  import lrbo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      exit_hi,
  input  logic      bo_hit,
  input  logic      trip,
  output bo_state_e state
);
  bo_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      BO_OFF:  if (exit_hi) nxt = BO_RUN;
      BO_RUN:  if (bo_hit) nxt = BO_RAMP;
      BO_RAMP: begin
        if (exit_hi) nxt = BO_RUN;
        else if (trip) nxt = BO_OFF;
      end
      default: nxt = BO_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= BO_OFF;
    else state <= nxt;
  end
endmodule

// File: rtl/lrbo_supervisor.sv
module lrbo_supervisor
  import lrbo_pkg::*;
#(
  parameter int LL_CYC  = 2500000,
  parameter int BO_CYC  = 5000000,
  parameter int WDG_CYC = 50000000,
  parameter logic [GAIN_W-1:0] GAIN_LL = 8'd5,
  parameter logic [GAIN_W-1:0] GAIN_HL = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              above_hl,
  input  logic              below_ll,
  input  logic              above_bo_exit,
  input  logic              below_bo_enter,
  input  logic              boost_en,
  input  logic              sw_active,
  input  logic              static_ovp_trip,
  output logic              low_line,
  output logic [GAIN_W-1:0] ton_gain,
  output logic              fb_offset_en,
  output logic              bo_fault,
  output logic              ramp_req,
  output logic              off_state
);
  // named internal events
  logic ll_cond, ll_hit, wdg_cond, wdg_hit, bo_cond, bo_hit;
  bo_state_e bo_state;

  assign ll_cond  = below_ll && !above_hl;
  assign wdg_cond = boost_en && !sw_active;
  assign bo_cond  = below_bo_enter && (bo_state == BO_RUN);

  lrbo_persist #(.N(LL_CYC)) u_ll_timer (
    .clk(clk), .rst_n(rst_n), .cond(ll_cond), .hit(ll_hit));

  lrbo_persist #(.N(WDG_CYC)) u_wdg_timer (
    .clk(clk), .rst_n(rst_n), .cond(wdg_cond), .hit(wdg_hit));

  lrbo_persist #(.N(BO_CYC)) u_bo_timer (
    .clk(clk), .rst_n(rst_n), .cond(bo_cond), .hit(bo_hit));

  lrbo_line_sel u_line (
    .clk(clk), .rst_n(rst_n), .go_high(above_hl),
    .wdg_hit(wdg_hit), .ll_hit(ll_hit), .low_line(low_line));

  lrbo_bo_ctrl u_bo (
    .clk(clk), .rst_n(rst_n), .exit_hi(above_bo_exit),
    .bo_hit(bo_hit), .trip(static_ovp_trip), .state(bo_state));

  assign ton_gain     = pick_gain(low_line, GAIN_LL, GAIN_HL);
  assign fb_offset_en = low_line && boost_en;
  assign bo_fault     = (bo_state != BO_RUN);
  assign ramp_req     = (bo_state == BO_RAMP);
  assign off_state    = (bo_state == BO_OFF);
endmodule

// File: rtl/lrbo_checker.sv
module lrbo_checker #(
  parameter int LL_CYC  = 8,
  parameter int BO_CYC  = 8,
  parameter int WDG_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic above_hl,
  input logic below_ll,
  input logic above_bo_exit,
  input logic below_bo_enter,
  input logic boost_en,
  input logic sw_active,
  input logic static_ovp_trip,
  input logic low_line,
  input logic bo_fault,
  input logic ramp_req,
  input logic off_state
);
  int ll_run, idle_run, bo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ll_run <= 0; idle_run <= 0; bo_run <= 0;
    end else begin
      ll_run   <= (below_ll && !above_hl) ? ((ll_run < LL_CYC) ? ll_run + 1 : ll_run) : 0;
      idle_run <= (boost_en && !sw_active) ? ((idle_run < WDG_CYC) ? idle_run + 1 : idle_run) : 0;
      bo_run   <= (below_bo_enter && !bo_fault) ? ((bo_run < BO_CYC) ? bo_run + 1 : bo_run) : 0;
    end
  end

  p_hl_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    above_hl |=> !low_line);
  p_ll_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_line) |-> (ll_run >= LL_CYC));
  p_wdg_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run >= WDG_CYC) |-> !low_line);
  p_recover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bo_fault) |-> $past(above_bo_exit));
  p_bo_persist_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bo_fault) |-> (bo_run >= BO_CYC));
  p_ramp_on_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bo_fault) |-> (ramp_req && !off_state));
  p_off_needs_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_state) |-> ($past(static_ovp_trip) && $past(ramp_req)));
  p_off_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (off_state && !above_bo_exit) |=> off_state);
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_req && off_state));
endmodule

bind lrbo_supervisor lrbo_checker #(
  .LL_CYC(LL_CYC), .BO_CYC(BO_CYC), .WDG_CYC(WDG_CYC)
) u_lrbo_checker (
  .clk(clk), .rst_n(rst_n), .above_hl(above_hl), .below_ll(below_ll),
  .above_bo_exit(above_bo_exit), .below_bo_enter(below_bo_enter),
  .boost_en(boost_en), .sw_active(sw_active), .static_ovp_trip(static_ovp_trip),
  .low_line(low_line), .bo_fault(bo_fault), .ramp_req(ramp_req),
  .off_state(off_state)
);

// File: tb/lrbo_supervisor_bench.sv
module lrbo_supervisor_bench;
  localparam int LL  = 8;
  localparam int BO  = 12;
  localparam int WDG = 20;

  logic clk = 1'b0;
  logic rst_n, above_hl, below_ll, above_bo_exit, below_bo_enter;
  logic boost_en, sw_active, static_ovp_trip;
  logic low_line, fb_offset_en, bo_fault, ramp_req, off_state;
  logic [7:0] ton_gain;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lrbo_supervisor #(.LL_CYC(LL), .BO_CYC(BO), .WDG_CYC(WDG)) u_lrbo_supervisor (
    .clk(clk), .rst_n(rst_n), .above_hl(above_hl), .below_ll(below_ll),
    .above_bo_exit(above_bo_exit), .below_bo_enter(below_bo_enter),
    .boost_en(boost_en), .sw_active(sw_active), .static_ovp_trip(static_ovp_trip),
    .low_line(low_line), .ton_gain(ton_gain), .fb_offset_en(fb_offset_en),
    .bo_fault(bo_fault), .ramp_req(ramp_req), .off_state(off_state));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; above_hl = 0; below_ll = 0; above_bo_exit = 0;
    below_bo_enter = 0; boost_en = 0; sw_active = 1; static_ovp_trip = 0;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 low_line", low_line, 0);
    chk("R1 bo_fault", bo_fault, 1);
    chk("R1 off_state", off_state, 1);
    chk("R1 ramp_req", ramp_req, 0);
    static_ovp_trip = 1; cyc(2); static_ovp_trip = 0;
    chk("R9 off holds under trip", off_state, 1);
  endtask

  task automatic t_recover;
    above_bo_exit = 1; cyc(1); above_bo_exit = 0;
    chk("R5 bo_fault cleared", bo_fault, 0);
    chk("R5 off_state cleared", off_state, 0);
    chk("R5 ramp_req low", ramp_req, 0);
  endtask

  task automatic t_low_line;
    below_ll = 1; cyc(LL - 1);
    chk("R3 early", low_line, 0);
    below_ll = 0; cyc(1); below_ll = 1; cyc(LL - 1);
    chk("R3 restart after break", low_line, 0);
    cyc(1);
    chk("R3 low line taken", low_line, 1);
    chk("R10 gain low", ton_gain, 5);
    chk("R10 offset off without boost", fb_offset_en, 0);
    above_hl = 1; below_ll = 0; cyc(1); above_hl = 0;
    chk("R2 immediate high line", low_line, 0);
    chk("R10 gain high", ton_gain, 2);
  endtask

  task automatic t_watchdog;
    below_ll = 1; cyc(LL);
    chk("R3 low line again", low_line, 1);
    boost_en = 1; cyc(1);
    chk("R10 offset on", fb_offset_en, 1);
    sw_active = 0; cyc(WDG - 1);
    chk("R4 before watchdog", low_line, 1);
    cyc(1);
    chk("R4 watchdog forces high", low_line, 0);
    cyc(LL + 2);
    chk("R4 held while idle", low_line, 0);
    sw_active = 1; cyc(LL);
    chk("R4 low line resumes", low_line, 1);
    boost_en = 0; sw_active = 0; cyc(WDG + 3);
    chk("R4 no watchdog without boost", low_line, 1);
    sw_active = 1; below_ll = 0; above_hl = 1; cyc(1); above_hl = 0;
    chk("R2 back to high", low_line, 0);
  endtask

  task automatic t_brownout;
    static_ovp_trip = 1; cyc(2); static_ovp_trip = 0;
    chk("R8 trip ignored in run", off_state, 0);
    below_bo_enter = 1; cyc(BO - 1);
    chk("R6 early", bo_fault, 0);
    below_bo_enter = 0; cyc(1); below_bo_enter = 1; cyc(BO - 1);
    chk("R6 restart after break", bo_fault, 0);
    cyc(1);
    chk("R6 fault set", bo_fault, 1);
    chk("R7 ramp requested", ramp_req, 1);
    chk("R7 switching continues", off_state, 0);
    below_bo_enter = 0; cyc(3);
    chk("R7 ramp persists", ramp_req, 1);
    static_ovp_trip = 1; cyc(1); static_ovp_trip = 0;
    chk("R8 off after trip", off_state, 1);
    chk("R8 ramp cleared", ramp_req, 0);
    cyc(5);
    chk("R9 off holds", off_state, 1);
    above_bo_exit = 1; cyc(1); above_bo_exit = 0;
    chk("R9 recovery from off", off_state, 0);
    chk("R5 fault cleared", bo_fault, 0);
    below_bo_enter = 1; cyc(BO); below_bo_enter = 0;
    chk("R6 fault again", ramp_req, 1);
    above_bo_exit = 1; cyc(1); above_bo_exit = 0;
    chk("R9 recovery from ramp", bo_fault, 0);
    chk("R9 ramp dropped", ramp_req, 0);
  endtask

  initial begin
    cyc(20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_recover();
    t_low_line();
    t_watchdog();
    t_brownout();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule